// File: doc/BRIEF.md
# Power Management Mode Controller

This block holds a small power-state register that software writes to pick a reduced clock rate, a doze state or a sleep state. From that register it drives plain control pins: a 4-bit slow-down factor for an external clock generator, one clock-gate request per functional unit (data cache, instruction cache, data MMU, instruction MMU, CPU core and tick timer), and a low-voltage hint for the supply. The gating cells, the clock dividers and the regulator live outside the block.

Doze stops every unit except the tick timer, so time keeping goes on. Sleep also stops the tick timer and requests a lower supply voltage. The interrupt controller's pending-interrupt line ends either state. The block then pulses a wake request and clears the state bits, so every gate request drops in the same cycle. Register writes are plain control accesses with no handshake. An external stall request holds the register against writes. There is no data stream, so no valid/ready interface is used.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Bits 3:0 of the power register hold the slow-down factor. The `slow_factor` output always equals the stored field, and `pm_rdata[3:0]` reads it back.
- R2: `low_volt` is high whenever the stored slow-down factor is 4'hF.
- R3: With bit 4 (doze) set and bit 5 (sleep) clear, `gate_dcache`, `gate_icache`, `gate_dmmu`, `gate_immu` and `gate_cpu` are high and `gate_tick` is low.
- R4: With bit 5 (sleep) set, all six gate requests are high. This holds whether or not bit 4 is also set, so sleep wins over doze.
- R5: With bit 5 (sleep) set, `low_volt` is high whatever the slow-down factor is.
- R6: A clock edge that samples `irq_pending` high while bit 4 or bit 5 is stored makes `wake_req` high for exactly the following cycle. A high `irq_pending` with neither bit stored gives no pulse.
- R7: That same edge clears bits 4 and 5 and keeps the slow-down field. All gate requests are low while `wake_req` is high. A write in that cycle still updates bits 3:0, but its bits 4 and 5 are discarded.
- R8: A write with `pm_we` high updates bits 5:0 on the next clock edge. Bits 31:6 of a write are discarded and always read as 0.
- R9: While `stall_req` is high, writes leave the register unchanged.
- R10: Asynchronous active-low `rst_n` clears the register and drives every gate request, `low_volt` and `wake_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pm_we | input | 1 | Register write strobe |
| pm_wdata | input | 32 | Register write data |
| pm_rdata | output | 32 | Register read-back value |
| stall_req | input | 1 | External stall; blocks register writes |
| irq_pending | input | 1 | Pending interrupt from the interrupt controller |
| slow_factor | output | 4 | Slow-down factor for the clock generator |
| gate_dcache | output | 1 | Clock-gate request, data cache |
| gate_icache | output | 1 | Clock-gate request, instruction cache |
| gate_dmmu | output | 1 | Clock-gate request, data MMU |
| gate_immu | output | 1 | Clock-gate request, instruction MMU |
| gate_cpu | output | 1 | Clock-gate request, CPU core |
| gate_tick | output | 1 | Clock-gate request, tick timer |
| wake_req | output | 1 | One-cycle request to re-enable all clocks |
| low_volt | output | 1 | Lower supply voltage indication |

## Verification
The gate requests and `low_volt` are decoded straight from the stored register with no further register stage. A wrong stored bit therefore shows on the gate pins and on `pm_rdata` in the cycle right after the edge that stored it. A fault in the wake path shows as a missing or stretched `wake_req` pulse, or as gate requests still high in the cycle after the interrupt edge. Vectors that combine an interrupt with a same-cycle write, or that set both mode bits, check the ordering rules one cycle after stimulus.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int PM_DATA_W  = 32;
  localparam int PM_SDF_W   = 4;
  localparam int PM_DOZE_B  = PM_SDF_W;
  localparam int PM_SLEEP_B = PM_SDF_W + 1;
  localparam int PM_UNITS   = 6;

  // gate vector bit order
  localparam int U_DCACHE = 0;
  localparam int U_ICACHE = 1;
  localparam int U_DMMU   = 2;
  localparam int U_IMMU   = 3;
  localparam int U_CPU    = 4;
  localparam int U_TICK   = 5;

  typedef struct packed {
    logic                sleep;
    logic                doze;
    logic [PM_SDF_W-1:0] sdf;
  } pm_state_t;
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int DATA_W = PM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_block,
  input  logic              wake_hit,
  output pm_state_t         state_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int STATE_W = $bits(pm_state_t);

  pm_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en && !wr_block) begin
      state_d.sdf   = wr_data[PM_SDF_W-1:0];
      state_d.doze  = wr_data[PM_DOZE_B];
      state_d.sleep = wr_data[PM_SLEEP_B];
    end
    if (wake_hit) begin
      state_d.doze  = 1'b0;
      state_d.sleep = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  always_comb begin
    rd_data              = '0;
    rd_data[STATE_W-1:0] = state_q;
  end
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_t state_q,
  input  logic      irq,
  output logic      wake_hit,
  output logic      wake_q
);
  logic low_power;

  assign low_power = state_q.doze | state_q.sleep;
  assign wake_hit  = low_power & irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_hit;
  end
endmodule

// File: rtl/pmc_gate_decode.sv
module pmc_gate_decode
  import pmc_pkg::*;
#(
  parameter int UNITS    = PM_UNITS,
  parameter int TICK_IDX = U_TICK
) (
  input  pm_state_t        state_q,
  output logic [UNITS-1:0] gate,
  output logic             low_volt
);
  localparam logic [PM_SDF_W-1:0] SDF_MAX = '1;

  logic any_lp;
  assign any_lp = state_q.doze | state_q.sleep;

  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    if (i == TICK_IDX) begin : g_keep_alive
      assign gate[i] = state_q.sleep;
    end else begin : g_core_unit
      assign gate[i] = any_lp;
    end
  end

  assign low_volt = state_q.sleep | (state_q.sdf == SDF_MAX);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pm_we,
  input  logic [PM_DATA_W-1:0] pm_wdata,
  output logic [PM_DATA_W-1:0] pm_rdata,
  input  logic                 stall_req,
  input  logic                 irq_pending,
  output logic [PM_SDF_W-1:0]  slow_factor,
  output logic                 gate_dcache,
  output logic                 gate_icache,
  output logic                 gate_dmmu,
  output logic                 gate_immu,
  output logic                 gate_cpu,
  output logic                 gate_tick,
  output logic                 wake_req,
  output logic                 low_volt
);
  pm_state_t            state_q;
  logic                 wake_hit;
  logic [PM_UNITS-1:0]  gate_vec;

  pmc_regs #(.DATA_W(PM_DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pm_we),
    .wr_data  (pm_wdata),
    .wr_block (stall_req),
    .wake_hit (wake_hit),
    .state_q  (state_q),
    .rd_data  (pm_rdata)
  );

  pmc_wake u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .irq      (irq_pending),
    .wake_hit (wake_hit),
    .wake_q   (wake_req)
  );

  pmc_gate_decode #(.UNITS(PM_UNITS), .TICK_IDX(U_TICK)) u_gate (
    .state_q  (state_q),
    .gate     (gate_vec),
    .low_volt (low_volt)
  );

  assign slow_factor = state_q.sdf;
  assign gate_dcache = gate_vec[U_DCACHE];
  assign gate_icache = gate_vec[U_ICACHE];
  assign gate_dmmu   = gate_vec[U_DMMU];
  assign gate_immu   = gate_vec[U_IMMU];
  assign gate_cpu    = gate_vec[U_CPU];
  assign gate_tick   = gate_vec[U_TICK];
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pm_rdata,
  input logic        stall_req,
  input logic        irq_pending,
  input logic [3:0]  slow_factor,
  input logic        gate_dcache,
  input logic        gate_icache,
  input logic        gate_dmmu,
  input logic        gate_immu,
  input logic        gate_cpu,
  input logic        gate_tick,
  input logic        wake_req,
  input logic        low_volt
);
  logic [5:0] gates;
  assign gates = {gate_tick, gate_cpu, gate_immu, gate_dmmu, gate_icache, gate_dcache};

  AST_SDF_ON_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    slow_factor == pm_rdata[3:0]);                                           // R1
  AST_SDF_MAX_LV: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_factor == 4'hF) |-> low_volt);                                     // R2
  AST_DOZE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_rdata[4] && !pm_rdata[5]) |-> (gates == 6'b011111));                 // R3
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rdata[5] |-> (gates == 6'b111111));                                   // R4
  AST_SLEEP_LV: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rdata[5] |-> low_volt);                                               // R5
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);                                                 // R6
  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> ($past(irq_pending) && ($past(pm_rdata[5:4]) != 2'b00))); // R6
  AST_WAKE_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (gates == 6'b000000 && pm_rdata[5:4] == 2'b00));            // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rdata[31:6] == 26'd0);                                                // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !(irq_pending && pm_rdata[5:4] != 2'b00)) |=> $stable(pm_rdata)); // R9
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pm_rdata    (pm_rdata),
  .stall_req   (stall_req),
  .irq_pending (irq_pending),
  .slow_factor (slow_factor),
  .gate_dcache (gate_dcache),
  .gate_icache (gate_icache),
  .gate_dmmu   (gate_dmmu),
  .gate_immu   (gate_immu),
  .gate_cpu    (gate_cpu),
  .gate_tick   (gate_tick),
  .wake_req    (wake_req),
  .low_volt    (low_volt)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_we = 1'b0;
  logic [31:0] pm_wdata = '0;
  logic [31:0] pm_rdata;
  logic        stall_req = 1'b0;
  logic        irq_pending = 1'b0;
  logic [3:0]  slow_factor;
  logic        gate_dcache, gate_icache, gate_dmmu, gate_immu, gate_cpu, gate_tick;
  logic        wake_req, low_volt;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .pm_we(pm_we), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
    .stall_req(stall_req), .irq_pending(irq_pending), .slow_factor(slow_factor),
    .gate_dcache(gate_dcache), .gate_icache(gate_icache), .gate_dmmu(gate_dmmu),
    .gate_immu(gate_immu), .gate_cpu(gate_cpu), .gate_tick(gate_tick),
    .wake_req(wake_req), .low_volt(low_volt)
  );

  // gate vector order: {tick, cpu, immu, dmmu, icache, dcache}
  function automatic logic [5:0] gates_now();
    return {gate_tick, gate_cpu, gate_immu, gate_dmmu, gate_icache, gate_dcache};
  endfunction

  // {req id(4), stall, we, wdata(8), irq, exp rd(8), exp gates(6), exp lv, exp wake}
  localparam int NV = 14;
  localparam logic [30:0] VEC [NV] = '{
    {4'd1,  1'b0, 1'b1, 8'h03, 1'b0, 8'h03, 6'h00, 1'b0, 1'b0}, // R1 plain factor
    {4'd2,  1'b0, 1'b1, 8'h0F, 1'b0, 8'h0F, 6'h00, 1'b1, 1'b0}, // R2 max factor
    {4'd3,  1'b0, 1'b1, 8'h12, 1'b0, 8'h12, 6'h1F, 1'b0, 1'b0}, // R3 doze
    {4'd6,  1'b0, 1'b0, 8'h00, 1'b1, 8'h02, 6'h00, 1'b0, 1'b1}, // R6 wake from doze
    {4'd6,  1'b0, 1'b0, 8'h00, 1'b1, 8'h02, 6'h00, 1'b0, 1'b0}, // R6 no second pulse
    {4'd5,  1'b0, 1'b1, 8'h25, 1'b0, 8'h25, 6'h3F, 1'b1, 1'b0}, // R5 sleep
    {4'd9,  1'b1, 1'b1, 8'h00, 1'b0, 8'h25, 6'h3F, 1'b1, 1'b0}, // R9 stalled write
    {4'd7,  1'b0, 1'b0, 8'h00, 1'b1, 8'h05, 6'h00, 1'b0, 1'b1}, // R7 wake from sleep
    {4'd4,  1'b0, 1'b1, 8'h37, 1'b0, 8'h37, 6'h3F, 1'b1, 1'b0}, // R4 both bits
    {4'd7,  1'b0, 1'b1, 8'h19, 1'b1, 8'h09, 6'h00, 1'b0, 1'b1}, // R7 write lost to wake
    {4'd8,  1'b0, 1'b1, 8'hFF, 1'b0, 8'h3F, 6'h3F, 1'b1, 1'b0}, // R8 bits 7:6 dropped
    {4'd3,  1'b0, 1'b1, 8'h1F, 1'b0, 8'h1F, 6'h1F, 1'b1, 1'b0}, // R3 doze with max factor
    {4'd7,  1'b0, 1'b0, 8'h00, 1'b1, 8'h0F, 6'h00, 1'b1, 1'b1}, // R7 factor kept
    {4'd2,  1'b0, 1'b0, 8'h00, 1'b0, 8'h0F, 6'h00, 1'b1, 1'b0}  // R2 idle
  };

  task automatic check(input string req, input logic [31:0] exp_rd, input logic [5:0] exp_g,
                       input logic exp_lv, input logic exp_wk);
    n_vec++;
    if (pm_rdata !== exp_rd || slow_factor !== exp_rd[3:0] || gates_now() !== exp_g ||
        low_volt !== exp_lv || wake_req !== exp_wk) begin
      n_bad++;
      $display("FAIL %s: rd=%h sdf=%h gates=%b lv=%b wake=%b, expected rd=%h sdf=%h gates=%b lv=%b wake=%b",
               req, pm_rdata, slow_factor, gates_now(), low_volt, wake_req,
               exp_rd, exp_rd[3:0], exp_g, exp_lv, exp_wk);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R10 reset state", 32'h0, 6'h00, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      @(negedge clk);
      stall_req   = v[26];
      pm_we       = v[25];
      pm_wdata    = {24'h0, v[24:17]};
      irq_pending = v[16];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", v[30:27], i),
            {24'h0, v[15:8]}, v[7:2], v[1], v[0]);
      pm_we = 1'b0; stall_req = 1'b0; irq_pending = 1'b0;
    end

    // R8: upper bits of a wide write are discarded
    pm_we = 1'b1; pm_wdata = 32'hFFFF_FFC6;
    @(negedge clk);
    pm_we = 1'b0;
    check("R8 upper write bits", 32'h06, 6'h00, 1'b0, 1'b0);

    // R6: pending interrupt with no low-power mode gives no pulse
    irq_pending = 1'b1;
    @(negedge clk);
    check("R6 idle irq", 32'h06, 6'h00, 1'b0, 1'b0);
    irq_pending = 1'b0;

    // R10: reset while asleep clears everything at once
    pm_we = 1'b1; pm_wdata = 32'h2A;
    @(negedge clk);
    pm_we = 1'b0;
    check("R5 sleep before reset", 32'h2A, 6'h3F, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R10 async reset", 32'h0, 6'h00, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 32'h0, 6'h00, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule